// File: doc/BRIEF.md
# Four-Channel Edge-Selectable Input Capture

This block timestamps external events. It watches four asynchronous input lines against one shared, free-running 16-bit timer value supplied from outside. Each channel has its own 2-bit edge selection: rising, falling, either, or off. When a channel's selected edge is seen, it copies the timer value into that channel's 16-bit capture register and raises that channel's interrupt flag. Software can read two captures from the same channel, subtract them, and obtain the interval between events.

The inputs are looked at only once per machine cycle, in the cycle marked by the `cyc_stb` strobe. The block first passes each input through a two-flop synchronizer. At each strobe it compares the synchronized level with the level it saw at the previous strobe. When the selected edge is present, the capture and the flag update happen on the clock edge that ends the strobe cycle. The timer value stored is the one present during that strobe cycle.

A small register port does three things: it writes and reads back the edge-select byte, it reads and clears the flags, and it reads the four capture registers. Software that does not need timestamps can ignore the capture registers and use the four flags as extra edge-triggered interrupt inputs.

Top module: `incap_unit`

## Requirements
- R1: After a synchronous active-low reset, the edge-select byte, all four capture registers, the flags and `irq_flags` read zero.
- R2: Edge-select bit 2n enables capture on a rising edge of channel n. With only that bit set, a falling edge on channel n captures nothing.
- R3: Edge-select bit 2n+1 enables capture on a falling edge of channel n. With only that bit set, a rising edge captures nothing.
- R4: With both bits 2n and 2n+1 set, channel n captures on every change of level between strobes.
- R5: With both edge bits of a channel clear, that channel never changes its capture register or its flag, whatever its input does.
- R6: An edge is judged only at a strobe, by comparing against the level sampled at the previous strobe. An input must be stable for two clocks before the strobe to be seen. A pulse that starts and ends between two strobes is not seen, and nothing changes while `cyc_stb` is low.
- R7: On a capture, the channel's register holds the `timer_val` present during the strobe cycle, readable from the next clock.
- R8: A capture sets channel n's flag (bit n of the flag register and of `irq_flags`). The flag stays set until software writes 1 to bit n at the flag address. Bits written as 0 leave their flags unchanged.
- R9: When a capture and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: Register map for the 3-bit address:
  - Address 0 is the edge-select byte (read/write).
  - Address 1 is the flags in bits 3:0 (read; write 1 to clear).
  - Addresses 2 to 5 are the capture registers of channels 0 to 3 (read only).
  - Reads are combinational and zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_stb | input | 1 | Marks the one clock per machine cycle in which inputs are judged |
| timer_val | input | 16 | Free-running timer value to be captured |
| cap_in | input | 4 | Asynchronous event inputs, one per channel |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write enable for the register port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq_flags | output | 4 | Per-channel interrupt flags |

## Verification
Directed steps drive each channel through rising and falling steps under each of the four edge selections. These steps show whether the two select bits are decoded to the right edge and to the right channel. A short pulse placed wholly between two strobes separates sampling at the strobe from sampling on every clock. A flag clear written in the same cycle as a fresh capture separates the two possible priorities. Random input levels, timer values, select bytes and clear masks are then applied at a fixed seed. These are compared against a bench model after every strobe, which catches cross-channel mix-ups and any register that moves without a qualified edge.

// File: rtl/cap_pkg.sv
// Package: shared address map and edge qualification helper for the
// input-capture unit. Assumes edge selection is two bits per channel,
// rising enable in the even bit, falling enable in the odd bit.
package cap_pkg;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_FLAGS = 1;
    localparam int ADDR_CAP0  = 2;

    // True when the level change from prev to cur matches the enables.
    function automatic logic edge_match(input logic rise_en, input logic fall_en,
                                        input logic cur, input logic prev);
        return (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
    endfunction

endpackage

// File: rtl/cap_sync.sv
// Two-flop synchronizer bank. Each bit of async_in is brought into the clk
// domain independently; a level must stay put for two clocks to appear.
module cap_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift each input through two flops; clear both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/cap_edge.sv
// Edge qualifier for one channel. Remembers the level seen at the last
// strobe and reports a hit in a strobe cycle whose level change matches
// the enabled edges. Assumes smp is already synchronized.
module cap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic smp,
    input  logic rise_en,
    input  logic fall_en,
    output logic hit
);
    import cap_pkg::*;

    logic prev_q;

    // Record the level observed at each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (stb) begin
            prev_q <= smp;
        end
    end

    // Qualify the edge only inside a strobe cycle.
    always_comb begin
        hit = stb & edge_match(rise_en, fall_en, smp, prev_q);
    end

    // R6: outside strobes the remembered level never moves.
    a_r6_prev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(prev_q));

endmodule

// File: rtl/cap_chan.sv
// Capture register and interrupt flag for one channel. On hit the timer
// value is latched and the flag set; a software clear only succeeds in a
// cycle without a hit.
module cap_chan #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             clr,
    input  logic [TMR_W-1:0] timer_val,
    output logic [TMR_W-1:0] cap_q,
    output logic             flag_q
);

    // Latch the timer value on a qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (hit) begin
            cap_q <= timer_val;
        end
    end

    // Set on capture, clear on request; capture wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    a_r7_value_taken: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cap_q == $past(timer_val));
    a_r5_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cap_q));
    a_r9_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr) |=> flag_q);
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);

endmodule

// File: rtl/cap_regs.sv
// Register port: holds the edge-select byte, turns flag-address writes into
// per-channel clear pulses, and muxes reads. Reads are combinational.
module cap_regs #(
    parameter int CH_N   = 4,
    parameter int TMR_W  = 16,
    parameter int CTRL_W = 2 * CH_N,
    parameter int ADDR_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_wr,
    input  logic [CTRL_W-1:0]          reg_wdata,
    input  logic [CH_N-1:0]            flags,
    input  logic [CH_N-1:0][TMR_W-1:0] caps,
    output logic [CTRL_W-1:0]          ctrl_q,
    output logic [CH_N-1:0]            clr_vec,
    output logic [TMR_W-1:0]           reg_rdata
);
    import cap_pkg::*;

    logic wr_ctrl;
    logic wr_flags;

    // Decode the two writable addresses.
    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
        wr_flags = reg_wr && (reg_addr == ADDR_W'(ADDR_FLAGS));
        clr_vec  = wr_flags ? reg_wdata[CH_N-1:0] : '0;
    end

    // Edge-select byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= reg_wdata;
        end
    end

    // Read multiplexer over control, flags and capture registers.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata = TMR_W'(ctrl_q);
        end else if (reg_addr == ADDR_W'(ADDR_FLAGS)) begin
            reg_rdata = TMR_W'(flags);
        end else begin
            for (int i = 0; i < CH_N; i++) begin
                if (reg_addr == ADDR_W'(ADDR_CAP0 + i)) begin
                    reg_rdata = caps[i];
                end
            end
        end
    end

    a_r10_ctrl_written: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(ADDR_CTRL)) |=> ctrl_q == $past(reg_wdata));
    a_r10_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_W'(ADDR_CTRL)) |=> $stable(ctrl_q));

endmodule

// File: rtl/incap_unit.sv
// Top of the four-channel input-capture unit. Inputs are synchronized,
// judged once per strobe against the enabled edges, and on a match the
// shared timer value is captured and the channel flag raised.
module incap_unit #(
    parameter int CH_N  = 4,
    parameter int TMR_W = 16,
    localparam int CTRL_W = 2 * CH_N,
    localparam int ADDR_W = $clog2(CH_N + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic [TMR_W-1:0]  timer_val,
    input  logic [CH_N-1:0]   cap_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [TMR_W-1:0]  reg_rdata,
    output logic [CH_N-1:0]   irq_flags
);

    logic [CH_N-1:0]            smp;
    logic [CH_N-1:0]            hit;
    logic [CH_N-1:0]            clr_vec;
    logic [CH_N-1:0]            flags;
    logic [CTRL_W-1:0]          ctrl_q;
    logic [CH_N-1:0][TMR_W-1:0] caps;

    cap_sync #(.WIDTH(CH_N)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cap_in),
        .sync_out (smp)
    );

    for (genvar n = 0; n < CH_N; n++) begin : g_chan
        cap_edge edge_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .stb     (cyc_stb),
            .smp     (smp[n]),
            .rise_en (ctrl_q[2*n]),
            .fall_en (ctrl_q[2*n+1]),
            .hit     (hit[n])
        );

        cap_chan #(.TMR_W(TMR_W)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (hit[n]),
            .clr       (clr_vec[n]),
            .timer_val (timer_val),
            .cap_q     (caps[n]),
            .flag_q    (flags[n])
        );
    end

    cap_regs #(
        .CH_N   (CH_N),
        .TMR_W  (TMR_W),
        .CTRL_W (CTRL_W),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .flags     (flags),
        .caps      (caps),
        .ctrl_q    (ctrl_q),
        .clr_vec   (clr_vec),
        .reg_rdata (reg_rdata)
    );

    assign irq_flags = flags;

    // R5: a channel with no edge enabled never hits.
    for (genvar n = 0; n < CH_N; n++) begin : g_chk
        a_r5_idle_channel: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[2*n+1 -: 2] == 2'b00) |-> !hit[n]);
    end

    // R6: no hit is ever reported outside a strobe.
    a_r6_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |-> (hit == '0));

endmodule

// File: tb/incap_unit_tb_top.sv
module incap_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_stb = 1'b0;
    logic [15:0] timer_val = '0;
    logic [3:0]  cap_in = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  irq_flags;

    int total = 0;
    int bad = 0;

    // Bench model of the requirements.
    logic [7:0]  m_ctrl = '0;
    logic [3:0]  m_prev = '0;
    logic [3:0]  m_flag = '0;
    logic [3:0]  m_in = '0;
    logic [15:0] m_cap [4];

    always #2 clk = ~clk;

    incap_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_stb   (cyc_stb),
        .timer_val (timer_val),
        .cap_in    (cap_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_flags (irq_flags)
    );

    // The edge rule from R2, R3 and R4.
    function automatic logic exp_hit(input logic rise, input logic fall,
                                     input logic cur, input logic prev);
        return (rise && cur && !prev) || (fall && !cur && prev);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    // Compare every readable value against the model.
    task automatic check_all(input string req);
        logic [15:0] v;
        check({req, " irq_flags"}, {12'h0, irq_flags}, {12'h0, m_flag});
        read_reg(3'd1, v);
        check({req, " flag reg"}, v, {12'h0, m_flag});
        for (int i = 0; i < 4; i++) begin
            read_reg(3'(2 + i), v);
            check({req, " capture"}, v, m_cap[i]);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        reg_addr = 3'd0; reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        m_ctrl = v;
    endtask

    task automatic write_clear(input logic [3:0] m);
        @(negedge clk);
        reg_addr = 3'd1; reg_wr = 1'b1; reg_wdata = {4'h0, m};
        @(negedge clk);
        reg_wr = 1'b0;
        m_flag = m_flag & ~m;
    endtask

    // Change the inputs and hold them long enough to pass the synchronizer.
    task automatic drive_in(input logic [3:0] v);
        @(negedge clk);
        cap_in = v;
        m_in = v;
        repeat (3) @(negedge clk);
    endtask

    // One strobe cycle, optionally carrying a flag clear.
    task automatic strobe(input logic [15:0] t, input logic do_clr, input logic [3:0] m);
        logic h;
        cyc_stb = 1'b1; timer_val = t;
        if (do_clr) begin
            reg_addr = 3'd1; reg_wr = 1'b1; reg_wdata = {4'h0, m};
        end
        @(negedge clk);
        cyc_stb = 1'b0; reg_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            h = exp_hit(m_ctrl[2*i], m_ctrl[2*i+1], m_in[i], m_prev[i]);
            if (h) begin
                m_cap[i] = t;
                m_flag[i] = 1'b1;
            end else if (do_clr && m[i]) begin
                m_flag[i] = 1'b0;
            end
            m_prev[i] = m_in[i];
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        logic [15:0] cap_snap;
        for (int i = 0; i < 4; i++) m_cap[i] = '0;
        void'($urandom(32'h1c0de5));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        read_reg(3'd0, v);
        check("R1 ctrl", v, 16'h0);
        check_all("R1");

        // R10: control readback and map
        write_ctrl(8'h55);
        read_reg(3'd0, v);
        check("R10 ctrl readback", v, 16'h0055);

        // R2: rising-only channels capture on rise
        drive_in(4'hF);
        strobe(16'h1234, 1'b0, 4'h0);
        check_all("R2 R7 R8 rising");
        // R2: falling edge ignored with rising-only select
        drive_in(4'h0);
        strobe(16'h2222, 1'b0, 4'h0);
        check_all("R2 fall ignored");

        // R8: partial clear
        write_clear(4'b0101);
        check_all("R8 partial clear");
        write_clear(4'b1010);

        // R3: falling-only
        write_ctrl(8'hAA);
        drive_in(4'hF);
        strobe(16'h3333, 1'b0, 4'h0);
        check_all("R3 rise ignored");
        drive_in(4'h0);
        strobe(16'h4444, 1'b0, 4'h0);
        check_all("R3 falling");
        write_clear(4'hF);

        // R4: either edge, mixed per channel
        write_ctrl(8'hFF);
        drive_in(4'b1010);
        strobe(16'h5555, 1'b0, 4'h0);
        check_all("R4 rise");
        drive_in(4'b0110);
        strobe(16'h6666, 1'b0, 4'h0);
        check_all("R4 mixed");
        write_clear(4'hF);

        // R5: channels disabled
        write_ctrl(8'h00);
        drive_in(4'b1001);
        strobe(16'h7777, 1'b0, 4'h0);
        check_all("R5 off");
        drive_in(4'b0110);
        strobe(16'h7778, 1'b0, 4'h0);
        check_all("R5 off");

        // R6: pulse between strobes is missed; nothing changes without strobe
        write_ctrl(8'hFF);
        strobe(16'h0100, 1'b0, 4'h0);
        write_clear(4'hF);
        read_reg(3'd2, cap_snap);
        drive_in(4'b1001);
        drive_in(4'b0110);
        read_reg(3'd2, v);
        check("R6 no strobe hold", v, cap_snap);
        strobe(16'h0200, 1'b0, 4'h0);
        check_all("R6 pulse missed");

        // R9: capture and clear in the same cycle
        write_ctrl(8'h01);
        drive_in(4'b0111);
        strobe(16'h0A0A, 1'b0, 4'h0);
        check_all("R9 setup");
        drive_in(4'b0110);
        strobe(16'h0B0B, 1'b0, 4'h0);
        drive_in(4'b0111);
        strobe(16'h0C0C, 1'b1, 4'h1);
        check_all("R9 capture wins");

        // Random mix
        for (int k = 0; k < 400; k++) begin
            if (($urandom % 4) == 0) write_ctrl(8'($urandom));
            drive_in(4'($urandom));
            if (($urandom % 3) == 0)
                strobe(16'($urandom), 1'b1, 4'($urandom));
            else
                strobe(16'($urandom), 1'b0, 4'h0);
            check_all("R2 R3 R4 R5 R7 R8 R9 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule